// File: doc/BRIEF.md
# Multicycle Accumulator Machine Control Unit

This block is the control and register datapath of a small decimal-style accumulator machine. Its state is a program counter, an instruction register, a memory address register (MAR), an accumulator and a negative flag. Each memory word holds a value from 0 to 999. The hundreds digit is the opcode and the low two digits are an address. An instruction runs as a chain of single register transfers, one transfer per clock.

The state machine has ten named states:

- FETCH_ADDR: PC goes to MAR.
- FETCH_INSTR: the memory word at MAR goes to IR.
- OPER_ADDR: the IR address field goes to MAR.
- MEM_XFER: a load, store, add or subtract against the word at MAR.
- IN_WAIT and OUT_WAIT: the port handshakes.
- SKIP_TEST: the conditional extra PC step.
- JUMP_LOAD: PC takes the IR address field.
- PC_STEP: PC increments.
- HALTED: the final state.

The transitions are:

- FETCH_ADDR goes to FETCH_INSTR.
- FETCH_INSTR branches on the instruction class: memory and arithmetic classes go to OPER_ADDR, input to IN_WAIT, output to OUT_WAIT, both skips to SKIP_TEST, jump to JUMP_LOAD, and everything else to HALTED.
- OPER_ADDR goes to MEM_XFER.
- MEM_XFER and SKIP_TEST go to PC_STEP.
- IN_WAIT stays until in_valid, then goes to PC_STEP.
- OUT_WAIT stays until out_ready, then goes to PC_STEP.
- JUMP_LOAD and PC_STEP return to FETCH_ADDR.
- HALTED stays in HALTED.

The memory port drives the value MAR will hold after the current edge. A synchronous memory that registers this address therefore returns the addressed word during the next step. That returned word acts as the data register for reads. For writes the accumulator is the data register image. MAR is never a source for any other register: it only feeds the memory address.

Top module: `acc_cpu_ctrl`

## Requirements
- R1: Reset clears PC, the accumulator, the negative flag and the halt flag. In the first step after reset, mem_addr is 0.
- R2: A fetch takes two steps. In the first, mem_addr shows PC. In the second, IR loads from mem_rdata. In the third step, mem_addr already shows the new IR's address field for memory-class instructions.
- R3: An instruction word w has opcode digit w/100 and address w%100. The default codes are:
  - 0: halt
  - 1: add
  - 2: subtract
  - 3: store
  - 5: load
  - 6: jump
  - 7: skip if accumulator is zero
  - 8: skip if not negative
  - 9: I/O, where address 1 is input and address 2 is output

  Any other opcode, or an I/O word with another address, halts.
- R4: Load takes 5 steps and sets the accumulator to the addressed word.
- R5: Store takes 5 steps. It raises mem_we for exactly one cycle, in its fourth step, with mem_addr equal to the operand address and mem_wdata equal to the accumulator.
- R6: Add and subtract take 5 steps. The result wraps modulo 1000. Subtract sets the negative flag when it borrows. Add, load and input clear the negative flag.
- R7: Input raises in_ready and output raises out_valid in their transfer step. Each holds that step until its handshake partner is high, so each takes 4 steps when the partner is already high. out_data equals the accumulator and stays stable while waiting.
- R8: A skip takes 4 steps. When its condition holds, PC advances by 2; otherwise it advances by 1.
- R9: A jump takes 3 steps and loads PC from the address field.
- R10: After the 2 fetch steps of a halting word, halted rises and stays high until reset. From then on, mem_we, in_ready and out_valid stay low and mem_addr holds still.
- R11: PC steps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 7 | Address for the synchronous memory (next MAR value) |
| mem_rdata | input | 10 | Word read from the address registered on the previous edge |
| mem_wdata | output | 10 | Write data (accumulator) |
| mem_we | output | 1 | Write strobe |
| in_data | input | 10 | Input port value, 0 to 999 |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Control unit accepts input this cycle |
| out_data | output | 10 | Output port value |
| out_valid | output | 1 | Output value presented |
| out_ready | input | 1 | Output consumer accepts |
| halted | output | 1 | Machine has stopped |

## Verification
Every result is due at a fixed step count measured from reset release:

- halted rises after the sum of the executed instructions' step counts (5, 4 or 3 each) plus the two fetch steps of the halting word.
- The operand address appears on mem_addr two edges after an instruction's first step.
- A store strobe appears three edges after it.

The bench runs directed programs and counts rising edges until halted. It compares that count with the sum worked out from the requirements. Single-cycle probes run in forked threads that wait a precomputed number of edges and sample 1 ns after the edge. Port stalls are added at known edges, so each stall adds exactly its own length to the expected count.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_INSTR,
        ST_OPER_ADDR,
        ST_MEM_XFER,
        ST_IN_WAIT,
        ST_OUT_WAIT,
        ST_SKIP_TEST,
        ST_JUMP_LOAD,
        ST_PC_STEP,
        ST_HALTED
    } step_e;

    typedef enum logic [3:0] {
        CL_LOAD,
        CL_STORE,
        CL_ADD,
        CL_SUB,
        CL_IN,
        CL_OUT,
        CL_SKIP_ZERO,
        CL_SKIP_NONNEG,
        CL_JUMP,
        CL_HALT
    } iclass_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic ir_load;
        logic acc_from_mem;
        logic acc_from_alu;
        logic acc_from_in;
        logic alu_sub;
        logic mem_we;
        logic pc_inc;
        logic pc_jump;
        logic in_ready;
        logic out_valid;
        logic halted;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
`timescale 1ns/1ps
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W          = 10,
    parameter int ADDR_W          = 7,
    parameter int FIELD_DIV       = 100,
    parameter int OPC_HALT        = 0,
    parameter int OPC_ADD         = 1,
    parameter int OPC_SUB         = 2,
    parameter int OPC_STORE       = 3,
    parameter int OPC_LOAD        = 5,
    parameter int OPC_JUMP        = 6,
    parameter int OPC_SKIP_ZERO   = 7,
    parameter int OPC_SKIP_NONNEG = 8,
    parameter int OPC_IO          = 9,
    parameter int IO_IN_SEL       = 1,
    parameter int IO_OUT_SEL      = 2
) (
    input  logic [DATA_W-1:0] word,
    output iclass_e           cls,
    output logic [ADDR_W-1:0] addr
);

    logic [DATA_W-1:0] digit;

    always_comb begin
        digit = word / DATA_W'(FIELD_DIV);
        addr  = ADDR_W'(word % DATA_W'(FIELD_DIV));
        if (digit == DATA_W'(OPC_LOAD))
            cls = CL_LOAD;
        else if (digit == DATA_W'(OPC_STORE))
            cls = CL_STORE;
        else if (digit == DATA_W'(OPC_ADD))
            cls = CL_ADD;
        else if (digit == DATA_W'(OPC_SUB))
            cls = CL_SUB;
        else if (digit == DATA_W'(OPC_JUMP))
            cls = CL_JUMP;
        else if (digit == DATA_W'(OPC_SKIP_ZERO))
            cls = CL_SKIP_ZERO;
        else if (digit == DATA_W'(OPC_SKIP_NONNEG))
            cls = CL_SKIP_NONNEG;
        else if (digit == DATA_W'(OPC_IO)) begin
            if (addr == ADDR_W'(IO_IN_SEL))
                cls = CL_IN;
            else if (addr == ADDR_W'(IO_OUT_SEL))
                cls = CL_OUT;
            else
                cls = CL_HALT;
        end
        else if (digit == DATA_W'(OPC_HALT))
            cls = CL_HALT;
        else
            cls = CL_HALT;   // unassigned codes stop the machine (R3)
    end

endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu #(
    parameter int DATA_W   = 10,
    parameter int WORD_MOD = 1000
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              do_sub,
    output logic [DATA_W-1:0] result,
    output logic              borrow
);

    localparam int SW = DATA_W + 1;

    logic [SW-1:0] wide_l, wide_r, sum, diff_wrap;

    always_comb begin
        wide_l    = {1'b0, lhs};
        wide_r    = {1'b0, rhs};
        sum       = wide_l + wide_r;
        diff_wrap = wide_l + SW'(WORD_MOD) - wide_r;
        borrow    = 1'b0;
        if (do_sub) begin
            if (lhs >= rhs) begin
                result = lhs - rhs;
            end else begin
                result = DATA_W'(diff_wrap);
                borrow = 1'b1;
            end
        end else if (sum >= SW'(WORD_MOD)) begin
            result = DATA_W'(sum - SW'(WORD_MOD));
        end else begin
            result = DATA_W'(sum);
        end
    end

endmodule

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  iclass_e cls,
    input  logic    acc_zero,
    input  logic    acc_neg,
    input  logic    in_valid,
    input  logic    out_ready,
    output step_e   state,
    output ctl_t    ctl
);

    step_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_FETCH_ADDR;
        else
            state <= nxt;
    end

    // transfer strobes and next step
    always_comb begin
        ctl = '0;
        nxt = state;
        unique case (state)
            ST_FETCH_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                nxt = ST_FETCH_INSTR;
            end
            ST_FETCH_INSTR: begin
                ctl.ir_load = 1'b1;
                case (cls)
                    CL_LOAD, CL_STORE, CL_ADD, CL_SUB: nxt = ST_OPER_ADDR;
                    CL_IN:                             nxt = ST_IN_WAIT;
                    CL_OUT:                            nxt = ST_OUT_WAIT;
                    CL_SKIP_ZERO, CL_SKIP_NONNEG:      nxt = ST_SKIP_TEST;
                    CL_JUMP:                           nxt = ST_JUMP_LOAD;
                    default:                           nxt = ST_HALTED;
                endcase
            end
            ST_OPER_ADDR: begin
                ctl.mar_from_ir = 1'b1;
                nxt = ST_MEM_XFER;
            end
            ST_MEM_XFER: begin
                case (cls)
                    CL_LOAD:  ctl.acc_from_mem = 1'b1;
                    CL_STORE: ctl.mem_we       = 1'b1;
                    CL_ADD:   ctl.acc_from_alu = 1'b1;
                    CL_SUB: begin
                        ctl.acc_from_alu = 1'b1;
                        ctl.alu_sub      = 1'b1;
                    end
                    default: ;
                endcase
                nxt = ST_PC_STEP;
            end
            ST_IN_WAIT: begin
                ctl.in_ready = 1'b1;
                if (in_valid) begin
                    ctl.acc_from_in = 1'b1;
                    nxt = ST_PC_STEP;
                end
            end
            ST_OUT_WAIT: begin
                ctl.out_valid = 1'b1;
                if (out_ready)
                    nxt = ST_PC_STEP;
            end
            ST_SKIP_TEST: begin
                ctl.pc_inc = ((cls == CL_SKIP_ZERO) && acc_zero) ||
                             ((cls == CL_SKIP_NONNEG) && !acc_neg);
                nxt = ST_PC_STEP;
            end
            ST_JUMP_LOAD: begin
                ctl.pc_jump = 1'b1;
                nxt = ST_FETCH_ADDR;
            end
            ST_PC_STEP: begin
                ctl.pc_inc = 1'b1;
                nxt = ST_FETCH_ADDR;
            end
            ST_HALTED: begin
                ctl.halted = 1'b1;
                nxt = ST_HALTED;
            end
            default: nxt = ST_HALTED;
        endcase
    end

    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_ADDR) |=> (state == ST_FETCH_INSTR));

    p_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IN_WAIT && !in_valid) |=> (state == ST_IN_WAIT));

    p_halt_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED) |=> (state == ST_HALTED));

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int MEM_WORDS       = 100,
    parameter int WORD_MOD        = 1000,
    parameter int OPC_HALT        = 0,
    parameter int OPC_ADD         = 1,
    parameter int OPC_SUB         = 2,
    parameter int OPC_STORE       = 3,
    parameter int OPC_LOAD        = 5,
    parameter int OPC_JUMP        = 6,
    parameter int OPC_SKIP_ZERO   = 7,
    parameter int OPC_SKIP_NONNEG = 8,
    parameter int OPC_IO          = 9,
    parameter int IO_IN_SEL       = 1,
    parameter int IO_OUT_SEL      = 2,
    localparam int ADDR_W         = $clog2(MEM_WORDS),
    localparam int DATA_W         = $clog2(WORD_MOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(MEM_WORDS - 1);

    logic [ADDR_W-1:0] pc_q, mar_q, mar_nxt, ir_addr;
    logic [DATA_W-1:0] ir_q, acc_q, dec_word, alu_y;
    logic              neg_q, alu_borrow;
    step_e             state;
    iclass_e           cls;
    ctl_t              ctl;

    // Decode the word arriving in FETCH_INSTR so the branch can be taken there.
    assign dec_word = (state == ST_FETCH_INSTR) ? mem_rdata : ir_q;

    acc_cpu_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_DIV(MEM_WORDS),
        .OPC_HALT(OPC_HALT), .OPC_ADD(OPC_ADD), .OPC_SUB(OPC_SUB),
        .OPC_STORE(OPC_STORE), .OPC_LOAD(OPC_LOAD), .OPC_JUMP(OPC_JUMP),
        .OPC_SKIP_ZERO(OPC_SKIP_ZERO), .OPC_SKIP_NONNEG(OPC_SKIP_NONNEG),
        .OPC_IO(OPC_IO), .IO_IN_SEL(IO_IN_SEL), .IO_OUT_SEL(IO_OUT_SEL)
    ) u_decode (
        .word (dec_word),
        .cls  (cls),
        .addr (ir_addr)
    );

    acc_cpu_alu #(.DATA_W(DATA_W), .WORD_MOD(WORD_MOD)) u_alu (
        .lhs    (acc_q),
        .rhs    (mem_rdata),
        .do_sub (ctl.alu_sub),
        .result (alu_y),
        .borrow (alu_borrow)
    );

    acc_cpu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .acc_zero  (acc_q == '0),
        .acc_neg   (neg_q),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .state     (state),
        .ctl       (ctl)
    );

    // MAR is a pure destination: its only reader is the memory address pin.
    always_comb begin
        if (ctl.mar_from_pc)
            mar_nxt = pc_q;
        else if (ctl.mar_from_ir)
            mar_nxt = ir_addr;
        else
            mar_nxt = mar_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mar_q <= mar_nxt;
            if (ctl.ir_load)
                ir_q <= mem_rdata;
            if (ctl.pc_jump)
                pc_q <= ir_addr;
            else if (ctl.pc_inc)
                pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
            if (ctl.acc_from_mem) begin
                acc_q <= mem_rdata;
                neg_q <= 1'b0;
            end else if (ctl.acc_from_alu) begin
                acc_q <= alu_y;
                neg_q <= alu_borrow;
            end else if (ctl.acc_from_in) begin
                acc_q <= in_data;
                neg_q <= 1'b0;
            end
        end
    end

    assign mem_addr  = mar_nxt;
    assign mem_wdata = acc_q;
    assign mem_we    = ctl.mem_we;
    assign in_ready  = ctl.in_ready;
    assign out_valid = ctl.out_valid;
    assign out_data  = acc_q;
    assign halted    = ctl.halted;

    p_pc_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pc_q) < MEM_WORDS);

    p_acc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_q) < WORD_MOD);

    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_we && !in_ready && !out_valid));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_jump |=> (pc_q == $past(ir_addr)));

endmodule

// File: tb/tb_acc_cpu_ctrl.sv
`timescale 1ns/1ps
module tb_acc_cpu_ctrl;

    localparam int AW = 7;
    localparam int DW = 10;
    localparam int NW = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          halted;

    int n_chk = 0;
    int n_fail = 0;
    int out_cnt = 0;
    int last_out = 0;

    logic          clr = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] mem [0:NW-1];

    always #4 clk = ~clk;   // 125 MHz

    acc_cpu_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .halted(halted)
    );

    // synchronous memory model with a bench loading path
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < NW; i++) mem[i] <= '0;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    // output port consumer, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            out_cnt  = out_cnt + 1;
            last_out = int'(out_data);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start();
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        in_data   = '0;
        clr       = 1'b1;
        @(posedge clk); #2;
        clr      = 1'b0;
        out_cnt  = 0;
        last_out = 0;
    endtask

    task automatic poke(input int a, input int d);
        ld_addr = AW'(a);
        ld_data = DW'(d);
        ld_en   = 1'b1;
        @(posedge clk); #2;
        ld_en = 1'b0;
    endtask

    task automatic release_rst();
        @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(input string req, input int exp_steps);
        int n = 0;
        while (!halted && n < 400) begin
            @(posedge clk); #2;
            n++;
        end
        chk(req, n, exp_steps);
    endtask

    // R1: reset state, accumulator cleared (shown by output of 0)
    task automatic t_reset();
        start();
        poke(0, 902);
        poke(1, 0);
        chk("R1 halted in reset", int'(halted), 0);
        chk("R1 we in reset", int'(mem_we), 0);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        release_rst();
        chk("R1 first fetch address", int'(mem_addr), 0);
        wait_halt("R1 R7 output steps", 6);
        chk("R1 acc cleared by reset", last_out, 0);
        chk("R1 output count", out_cnt, 1);
    endtask

    // R2 R3 R4 R5: load then store
    task automatic t_load_store();
        start();
        poke(0, 510);
        poke(1, 311);
        poke(2, 0);
        poke(10, 123);
        release_rst();
        fork
            begin
                repeat (2) @(posedge clk); #1;
                chk("R2 R3 operand address after fetch", int'(mem_addr), 10);
                repeat (6) @(posedge clk); #1;
                chk("R5 store strobe", int'(mem_we), 1);
                chk("R5 store address", int'(mem_addr), 11);
                chk("R5 store data", int'(mem_wdata), 123);
                @(posedge clk); #1;
                chk("R5 strobe one cycle", int'(mem_we), 0);
            end
        join_none
        wait_halt("R4 R5 step count", 12);
        chk("R4 R5 stored value", int'(mem[11]), 123);
    endtask

    // R6: modulo add and borrowing subtract
    task automatic t_arith();
        start();
        poke(0, 520); poke(1, 121); poke(2, 330);
        poke(3, 222); poke(4, 331); poke(5, 0);
        poke(20, 700); poke(21, 450); poke(22, 200);
        release_rst();
        wait_halt("R6 step count", 27);
        chk("R6 add wraps", int'(mem[30]), 150);
        chk("R6 sub borrows", int'(mem[31]), 950);
    endtask

    // R8: both skip kinds, taken and not taken
    task automatic t_skip();
        start();
        poke(0, 520); poke(1, 700); poke(2, 330); poke(3, 521);
        poke(4, 700); poke(5, 331); poke(6, 222); poke(7, 800);
        poke(8, 332); poke(9, 520); poke(10, 800); poke(11, 333);
        poke(12, 0);
        poke(20, 0); poke(21, 5); poke(22, 9);
        poke(30, 777); poke(31, 777); poke(32, 777); poke(33, 777);
        release_rst();
        wait_halt("R8 step count", 48);
        chk("R8 zero skip taken", int'(mem[30]), 777);
        chk("R8 zero skip not taken", int'(mem[31]), 5);
        chk("R8 R6 nonneg skip not taken", int'(mem[32]), 996);
        chk("R8 nonneg skip taken", int'(mem[33]), 777);
    endtask

    // R9: jump
    task automatic t_jump();
        start();
        poke(0, 605); poke(1, 330);
        poke(5, 520); poke(6, 331); poke(7, 0);
        poke(20, 42); poke(30, 777);
        release_rst();
        wait_halt("R9 step count", 15);
        chk("R9 jumped over", int'(mem[30]), 777);
        chk("R9 target ran", int'(mem[31]), 42);
    endtask

    // R7: input stall and output handshake
    task automatic t_io_in();
        start();
        poke(0, 901); poke(1, 340); poke(2, 541); poke(3, 902); poke(4, 0);
        poke(41, 654);
        in_data = DW'(321);
        release_rst();
        fork
            begin
                repeat (4) @(posedge clk); #1;
                chk("R7 in_ready while waiting", int'(in_ready), 1);
                @(posedge clk); #1;
                in_valid = 1'b1;
            end
        join_none
        wait_halt("R7 input stall steps", 23);
        chk("R7 input captured", int'(mem[40]), 321);
        chk("R7 output value", last_out, 654);
        chk("R7 output count", out_cnt, 1);
    endtask

    task automatic t_io_out();
        start();
        poke(0, 541); poke(1, 902); poke(2, 0);
        poke(41, 654);
        out_ready = 1'b0;
        release_rst();
        fork
            begin
                repeat (9) @(posedge clk); #1;
                chk("R7 out_valid held", int'(out_valid), 1);
                chk("R7 out_data held", int'(out_data), 654);
                @(posedge clk); #1;
                out_ready = 1'b1;
            end
        join_none
        wait_halt("R7 output stall steps", 14);
        chk("R7 single transfer", out_cnt, 1);
    endtask

    // R10 R3: unassigned opcode and unknown I/O select halt; halt is quiet
    task automatic t_halt();
        start();
        poke(0, 450);
        in_valid = 1'b1;
        release_rst();
        wait_halt("R10 R3 unassigned opcode halts", 2);
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #2;
            chk("R10 halted stays", int'(halted), 1);
            chk("R10 no write", int'(mem_we), 0);
            chk("R10 input ignored", int'(in_ready), 0);
            chk("R10 address held", int'(mem_addr), 0);
        end
        start();
        poke(0, 903);
        release_rst();
        wait_halt("R10 R3 unknown I/O select halts", 2);
    endtask

    // R11: PC wraps from 99 to 0
    task automatic t_wrap();
        start();
        poke(0, 700); poke(1, 0); poke(2, 698);
        poke(98, 520); poke(99, 330);
        poke(20, 5);
        release_rst();
        wait_halt("R11 step count", 23);
        chk("R11 store at 99 ran", int'(mem[30]), 5);
        chk("R11 halted at word 1", int'(mem_addr), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_load_store();
        t_reset();
        t_arith();
        t_skip();
        t_jump();
        t_io_in();
        t_io_out();
        t_halt();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule